// File: doc/BRIEF.md
# Packed Integer Compare-to-Mask Unit

This block takes two packed integer vectors and compares them lane by lane. Each lane produces a single result bit, and those bits are gathered into a mask word rather than written back as vector data. A control field sets the lane width to 8, 16, 32 or 64 bits. Each comparison can treat the lanes as signed or as unsigned values. A 3-bit predicate code selects one of eight relations, and two of those relations are the constants false and true.

A second operating mode replaces the relational compare with a bitwise test. The unit ANDs the two lanes together and reports, per lane, whether that result is non-zero or, in an inverted variant, whether it is zero. An optional qualifying mask decides which lanes are allowed to produce a set bit. The result is captured in a register, and `result_valid` pulses one clock after `start`.

Top module: `vec_cmp_mask`

## Requirements
- R1: `result_valid` is high in exactly the cycle after a clock edge that samples `start` high, and low after any edge that samples `start` low. `result_mask` only changes on an edge that samples `start` high.
- R2: In compare mode, predicate code 0 means equal, 1 less-than, 2 less-or-equal, 3 always false, 4 not-equal, 5 not-less-than, 6 not-less-or-equal, and 7 always true. Each relation is evaluated as a op b.
- R3: `is_signed`=1 compares lanes as two's-complement values, and `is_signed`=0 compares them as unsigned values.
- R4: `width_sel` 0, 1, 2 and 3 select 8-, 16-, 32- and 64-bit lanes. Lane i occupies bits [i*W +: W] of each operand, and its result goes to `result_mask` bit i.
- R5: Mask bits at or above the lane count (VEC_BITS/W) are written as zero.
- R6: With `qual_use`=0, every lane takes part, whatever `qual_mask` holds.
- R7: With `qual_use`=1, a lane whose `qual_mask` bit is 0 produces a 0 result bit.
- R8: `mode`=1 (test) sets a lane's bit when the AND of its two elements is non-zero.
- R9: `mode`=2 (inverted test) sets a lane's bit when the AND of its two elements is zero. `mode` values 0 and 3 both select compare.
- R10: While reset is held, `result_valid` and `result_mask` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture a new result on this edge |
| a | input | VEC_BITS | First operand vector |
| b | input | VEC_BITS | Second operand vector |
| pred | input | 3 | Relation code for compare mode |
| is_signed | input | 1 | Signed lane compare when 1 |
| width_sel | input | 2 | Lane width: 8, 16, 32 or 64 bits |
| mode | input | 2 | 0/3 compare, 1 test, 2 inverted test |
| qual_use | input | 1 | Apply the qualifying mask when 1 |
| qual_mask | input | VEC_BITS/8 | Per-lane enable bits |
| result_mask | output | VEC_BITS/8 | Registered per-lane result |
| result_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
Every result comes out exactly one clock edge after the edge that samples `start`, because the datapath is combinational up to a single output register. The bench drives its inputs on a falling edge and raises `start` there. It then samples the mask and valid on the next falling edge, which is the first point where that register has been updated. It also checks that `result_valid` is low, and the mask is unchanged, one falling edge later while new operands are applied with `start` low.

// File: rtl/vec_cmp_mask.sv
module vec_cmp_mask #(
  parameter int VEC_BITS = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [VEC_BITS-1:0]     a,
  input  logic [VEC_BITS-1:0]     b,
  input  logic [2:0]              pred,
  input  logic                    is_signed,
  input  logic [1:0]              width_sel,
  input  logic [1:0]              mode,
  input  logic                    qual_use,
  input  logic [VEC_BITS/8-1:0]   qual_mask,
  output logic [VEC_BITS/8-1:0]   result_mask,
  output logic                    result_valid
);
  localparam int MW = VEC_BITS / 8;

  function automatic logic rel(input logic [2:0] p, input logic eq, input logic lt);
    logic base;
    case (p[1:0])
      2'd0: base = eq;
      2'd1: base = lt;
      2'd2: base = lt | eq;
      default: base = 1'b0;
    endcase
    return base ^ p[2];
  endfunction

  for (genvar g = 0; g < 4; g++) begin : gw
    localparam int W = 8 << g;
    localparam int N = VEC_BITS / W;
    logic [MW-1:0] r;
    for (genvar i = 0; i < N; i++) begin : gl
      logic [W-1:0] ea, eb;
      logic         eq, lt, hit;
      assign ea  = a[i*W +: W];
      assign eb  = b[i*W +: W];
      assign eq  = (ea == eb);
      assign lt  = {ea[W-1] ^ is_signed, ea[W-2:0]} < {eb[W-1] ^ is_signed, eb[W-2:0]};
      assign hit = (mode == 2'd1) ?  (|(ea & eb)) :
                   (mode == 2'd2) ? ~(|(ea & eb)) : rel(pred, eq, lt);
      assign r[i] = hit;
    end
    if (N < MW) begin : gz
      assign r[MW-1:N] = '0;
    end
  end

  logic [MW-1:0] sel, lane_en;

  always_comb begin
    case (width_sel)
      2'd0:    sel = gw[0].r;
      2'd1:    sel = gw[1].r;
      2'd2:    sel = gw[2].r;
      default: sel = gw[3].r;
    endcase
  end

  assign lane_en = qual_use ? qual_mask : {MW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_mask  <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= start;
      if (start) result_mask <= sel & lane_en;
    end
  end
endmodule

// File: rtl/vec_cmp_mask_chk.sv
module vec_cmp_mask_chk #(
  parameter int VEC_BITS = 128
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic [VEC_BITS-1:0]   a,
  input logic [2:0]            pred,
  input logic [1:0]            width_sel,
  input logic [1:0]            mode,
  input logic                  qual_use,
  input logic [VEC_BITS/8-1:0] qual_mask,
  input logic [VEC_BITS/8-1:0] result_mask,
  input logic                  result_valid
);
  localparam int MW = VEC_BITS / 8;

  a_r1_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> result_valid);
  a_r1_valid_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !result_valid);
  a_r1_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(result_mask));
  a_r2_false_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 2'd0 && pred == 3'd3) |=> result_mask == '0);
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start && width_sel == 2'd3) |=> (result_mask >> (VEC_BITS/64)) == '0);
  a_r6_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !qual_use && mode == 2'd0 && pred == 3'd7 && width_sel == 2'd0)
      |=> result_mask == {MW{1'b1}});
  a_r7_disabled_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (start && qual_use) |=> (result_mask & ~$past(qual_mask)) == '0);
  a_r8_test_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 2'd1 && a == '0) |=> result_mask == '0);
  a_r10_reset_state: assert property (@(posedge clk)
    !rst_n |-> (!result_valid && result_mask == '0));
endmodule

bind vec_cmp_mask vec_cmp_mask_chk #(.VEC_BITS(VEC_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .a(a), .pred(pred),
  .width_sel(width_sel), .mode(mode), .qual_use(qual_use),
  .qual_mask(qual_mask), .result_mask(result_mask), .result_valid(result_valid)
);

// File: tb/vec_cmp_mask_test.sv
module vec_cmp_mask_test;
  localparam int VB = 128;
  localparam int MW = VB / 8;

  typedef struct packed {
    logic [VB-1:0] a;
    logic [VB-1:0] b;
    logic [2:0]    pred;
    logic          sgn;
    logic [1:0]    wsel;
    logic [1:0]    mode;
    logic          quse;
    logic [MW-1:0] qm;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{128'h00112233_44556677_8899AABB_CCDDEEFF, 128'h00112233_44556677_8899AABB_CCDDEEFF, 3'd0, 1'b0, 2'd0, 2'd0, 1'b0, 16'h0000},
    '{128'h80017FFF_00000005_FFFFFFFF_12345678, 128'h7FFF8000_00000006_00000001_12345678, 3'd1, 1'b1, 2'd1, 2'd0, 1'b0, 16'h0000},
    '{128'h80017FFF_00000005_FFFFFFFF_12345678, 128'h7FFF8000_00000006_00000001_12345678, 3'd1, 1'b0, 2'd1, 2'd0, 1'b0, 16'h0000},
    '{128'hFFFFFFFF_00000010_80000000_00000003, 128'h00000001_00000010_7FFFFFFF_00000004, 3'd2, 1'b1, 2'd2, 2'd0, 1'b0, 16'h0000},
    '{128'hFFFFFFFF_00000010_80000000_00000003, 128'h00000001_00000010_7FFFFFFF_00000004, 3'd6, 1'b0, 2'd2, 2'd0, 1'b0, 16'h0000},
    '{128'h80000000_00000000_00000000_00000009, 128'h00000000_00000001_00000000_00000009, 3'd5, 1'b1, 2'd3, 2'd0, 1'b0, 16'h0000},
    '{128'h01FF7F80_10203040_AA55AA55_00FF00FF, 128'h02FE7F81_10213040_55AA55AA_00FF0000, 3'd4, 1'b0, 2'd0, 2'd0, 1'b1, 16'hF0F0},
    '{128'h01FF7F80_10203040_AA55AA55_00FF00FF, 128'h02FE7F81_10213040_55AA55AA_00FF0000, 3'd2, 1'b1, 2'd0, 2'd0, 1'b0, 16'h0000},
    '{128'h0F0F0000_F0F0FFFF_00010002_80000000, 128'hF0F01234_0F0F0001_00030004_80000000, 3'd0, 1'b0, 2'd1, 2'd1, 1'b0, 16'h0000},
    '{128'h0F0F0000_F0F0FFFF_00010002_80000000, 128'hF0F01234_0F0F0001_00030004_80000000, 3'd0, 1'b0, 2'd1, 2'd2, 1'b1, 16'h00AA},
    '{128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF, 128'hDEADBEEF_CAFEF00E_01234567_89ABCDEE, 3'd4, 1'b1, 2'd2, 2'd3, 1'b0, 16'h0000},
    '{128'h12345678_9ABCDEF0_0FEDCBA9_87654321, 128'h00000000_00000000_00000000_00000000, 3'd7, 1'b0, 2'd3, 2'd0, 1'b1, 16'h0002}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [VB-1:0] a = '0, b = '0;
  logic [2:0] pred = '0;
  logic is_signed = 1'b0;
  logic [1:0] width_sel = '0, mode = '0;
  logic qual_use = 1'b0;
  logic [MW-1:0] qual_mask = '0;
  logic [MW-1:0] result_mask;
  logic result_valid;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vec_cmp_mask #(.VEC_BITS(VB)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b), .pred(pred),
    .is_signed(is_signed), .width_sel(width_sel), .mode(mode),
    .qual_use(qual_use), .qual_mask(qual_mask),
    .result_mask(result_mask), .result_valid(result_valid)
  );

  function automatic logic [MW-1:0] model(vec_t v);
    logic [MW-1:0] res = '0;
    int w = 8 << v.wsel;
    logic [63:0] msk = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    for (int i = 0; i < VB / w; i++) begin
      logic [63:0] ea = 64'((v.a >> (i * w))) & msk;
      logic [63:0] eb = 64'((v.b >> (i * w))) & msk;
      logic signed [64:0] sa = {1'b0, ea};
      logic signed [64:0] sb = {1'b0, eb};
      logic bit_r;
      if (v.sgn && ea[w-1]) sa = {1'b1, ea | ~msk};
      if (v.sgn && eb[w-1]) sb = {1'b1, eb | ~msk};
      if (v.mode == 2'd1)      bit_r = (ea & eb) != 64'd0;
      else if (v.mode == 2'd2) bit_r = (ea & eb) == 64'd0;
      else case (v.pred)
        3'd0: bit_r = sa == sb;
        3'd1: bit_r = sa <  sb;
        3'd2: bit_r = sa <= sb;
        3'd3: bit_r = 1'b0;
        3'd4: bit_r = sa != sb;
        3'd5: bit_r = sa >= sb;
        3'd6: bit_r = sa >  sb;
        default: bit_r = 1'b1;
      endcase
      if (v.quse && !v.qm[i]) bit_r = 1'b0;
      res[i] = bit_r;
    end
    return res;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    a = v.a; b = v.b; pred = v.pred; is_signed = v.sgn;
    width_sel = v.wsel; mode = v.mode; qual_use = v.quse; qual_mask = v.qm;
  endtask

  task automatic fire(vec_t v);
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic directed(string tag, vec_t v, logic [MW-1:0] exp);
    fire(v);
    check({tag, " valid"}, 64'(result_valid), 64'd1);
    check(tag, 64'(result_mask), 64'(exp));
  endtask

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 valid in reset", 64'(result_valid), 64'd0);
    check("R10 mask in reset", 64'(result_mask), 64'd0);
    rst_n = 1'b1;

    // R2 R3 R4 R8 R9: table walk against the lane model
    for (int k = 0; k < NV; k++) begin
      fire(TBL[k]);
      check($sformatf("R1 valid entry %0d", k), 64'(result_valid), 64'd1);
      check($sformatf("R2/R4 mask entry %0d", k), 64'(result_mask), 64'(model(TBL[k])));
    end

    // R2: equal on identical 8-bit lanes
    v = '{a: {VB{1'b1}}, b: {VB{1'b1}}, pred: 3'd0, sgn: 1'b0, wsel: 2'd0, mode: 2'd0, quse: 1'b0, qm: '0};
    directed("R2 equal all", v, 16'hFFFF);
    // R3: signed 0x80 < 0x01 in lane 0
    v = '{a: 128'h80, b: 128'h01, pred: 3'd1, sgn: 1'b1, wsel: 2'd0, mode: 2'd0, quse: 1'b0, qm: '0};
    directed("R3 signed lt", v, 16'h0001);
    v.sgn = 1'b0;
    directed("R3 unsigned lt", v, 16'h0000);
    // R5: 64-bit lanes with always-true leave upper bits zero
    v = '{a: '0, b: '0, pred: 3'd7, sgn: 1'b0, wsel: 2'd3, mode: 2'd0, quse: 1'b0, qm: '0};
    directed("R5 upper bits", v, 16'h0003);
    // R6: qual ignored when qual_use=0
    v = '{a: '0, b: '0, pred: 3'd7, sgn: 1'b0, wsel: 2'd0, mode: 2'd0, quse: 1'b0, qm: 16'h0000};
    directed("R6 all lanes", v, 16'hFFFF);
    // R7: disabled lanes read zero
    v.quse = 1'b1; v.qm = 16'hA5A5;
    directed("R7 qual mask", v, 16'hA5A5);
    // R8 / R9: test modes on 32-bit lanes
    v = '{a: 128'h00000000_00000001_000000F0_00000000,
          b: 128'hFFFFFFFF_00000001_0000000F_00000000,
          pred: 3'd0, sgn: 1'b0, wsel: 2'd2, mode: 2'd1, quse: 1'b0, qm: '0};
    directed("R8 test nonzero", v, 16'h0004);
    v.mode = 2'd2;
    directed("R9 test zero", v, 16'h000B);
    // R9: mode 3 acts as compare
    v = '{a: 128'h5, b: 128'h9, pred: 3'd7, sgn: 1'b0, wsel: 2'd1, mode: 2'd3, quse: 1'b0, qm: '0};
    directed("R9 mode3 compare", v, 16'h00FF);

    // R1: no start -> valid low, mask held despite new operands
    @(negedge clk);
    v = '{a: '0, b: '0, pred: 3'd3, sgn: 1'b0, wsel: 2'd0, mode: 2'd0, quse: 1'b0, qm: '0};
    drive(v);
    check("R1 valid drops", 64'(result_valid), 64'd0);
    @(negedge clk);
    check("R1 mask held", 64'(result_mask), 64'h00FF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule